// File: doc/BRIEF.md
# Daisy-Chain Serial Shift Register with Selectable Output Edge

This block is the 16-bit shift register that sits behind a serial slave port. While chip select is low, each rising edge of the serial clock moves one bit from the data input into the register, most significant bit first. The bit that leaves the top of the register drives a serial data output. Several devices can therefore be placed in a chain: each device's output feeds the next device's input, and all of them share the clock and the chip select. The full register is also offered as a parallel word to a command decoder, which reads it once chip select has gone high.

The output is re-timed on an edge that a mode input selects. In falling-edge mode, the output bit changes on the falling clock edge. A bit is then 16 clock periods behind the input, which suits downstream devices that sample on the rising edge. In rising-edge mode, the output comes straight from the register and changes on the rising edge, 15.5 periods behind the input. The mode is captured when chip select falls, so the output edge cannot change in the middle of a word.

Top module: `dcs_shift_out`

## Requirements
- R1: While rst_ni is low, word_o is 0 and sdo_o is 0, and the captured mode is falling-edge (mode_i value 0).
- R2: On each rising sclk_i edge with cs_ni low, word_o becomes {word_o[14:0], sdi_i}, so the first bit shifted ends up in bit 15.
- R3: While cs_ni is high, word_o holds its value whatever sdi_i and sclk_i do; after cs_ni rises it equals the last 16 bits shifted in.
- R4: In falling-edge mode (mode_i = 0 at the cs_ni fall), sdo_o changes only on falling sclk_i edges. After the falling edge that follows the k-th rising edge of a frame, it equals bit 15 of word_o as it stood after that rising edge.
- R5: In rising-edge mode (mode_i = 1 at the cs_ni fall), sdo_o equals word_o[15] and changes on the rising sclk_i edge.
- R6: mode_i is sampled only at the falling edge of cs_ni. A change of mode_i while cs_ni is low has no effect on sdo_o timing until the next frame.
- R7: While cs_ni is high, sdo_o holds its last value.
- R8: Two instances chained in falling-edge mode (sdo_o to sdi_i, with a shared clock and chip select), sent 32 bits in one frame, end with the downstream word equal to the first 16 bits and the upstream word equal to the last 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; frames a word |
| sdi_i | input | 1 | Serial data input |
| mode_i | input | 1 | Output edge select: 0 for the falling edge, 1 for the rising edge |
| sdo_o | output | 1 | Serial data output for chaining |
| word_o | output | WORD_W | Parallel shift-register contents for the command decoder |

## Verification
Every cycle, the checker confirms four things: the shift relation of the parallel word on each rising edge, that the word and the output hold while deselected, that the captured mode is stable inside a frame, and that the output matches the register's top bit on the correct edge for each mode. Only the bench's scenarios can show the 16 versus 15.5 period lag as seen from outside, as half-period samples taken after rising and after falling edges. The same holds for a mid-frame mode change having no effect, and for the end-to-end word transfer through a two-device chain.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned DefWordW = 16;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/dcs_shreg.sv
module dcs_shreg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              d_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[WORD_W-2:0], d_i};
  end
endmodule

// File: rtl/dcs_mode_cap.sv
module dcs_mode_cap
  import dcs_pkg::*;
(
  input  logic       cs_ni,
  input  logic       rst_ni,
  input  logic       mode_i,
  output edge_mode_e mode_o
);
  // frame start is the only sampling point
  always_ff @(negedge cs_ni or negedge rst_ni) begin
    if (!rst_ni) mode_o <= EDGE_FALL;
    else         mode_o <= edge_mode_e'(mode_i);
  end
endmodule

// File: rtl/dcs_out_retime.sv
module dcs_out_retime
  import dcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       msb_i,
  input  edge_mode_e mode_i,
  output logic       sdo_o
);
  logic fall_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fall_q <= 1'b0;
    else if (en_i) fall_q <= msb_i;
  end

  // rising mode: register top bit already changes on the rising edge
  assign sdo_o = (mode_i == EDGE_RISE) ? msb_i : fall_q;
endmodule

// File: rtl/dcs_shift_out.sv
module dcs_shift_out
  import dcs_pkg::*;
#(
  parameter int unsigned WORD_W = DefWordW
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              mode_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned MsbIdx = WORD_W - 1;

  logic       shift_en;
  edge_mode_e mode_q;

  assign shift_en = ~cs_ni;

  dcs_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk_i (sclk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .d_i   (sdi_i),
    .q_o   (word_o)
  );

  dcs_mode_cap u_mode (
    .cs_ni (cs_ni),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .mode_o(mode_q)
  );

  dcs_out_retime u_retime (
    .clk_i (sclk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .msb_i (word_o[MsbIdx]),
    .mode_i(mode_q),
    .sdo_o (sdo_o)
  );
endmodule

// File: rtl/dcs_shift_out_chk.sv
module dcs_shift_out_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdi_i,
  input logic              mode_q,
  input logic              sdo_o,
  input logic [WORD_W-1:0] word_o
);
  p_reset_clear_r1: assert property (@(posedge sclk_i)
    !rst_ni |-> (word_o == '0 && sdo_o == 1'b0 && mode_q == 1'b0));

  p_shift_in_r2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !cs_ni |=> word_o == {$past(word_o[WORD_W-2:0]), $past(sdi_i)});

  p_word_hold_r3: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(word_o));

  p_fall_out_r4: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && mode_q == 1'b0) |=> sdo_o == $past(word_o[WORD_W-1]));

  p_rise_out_r5: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && mode_q == 1'b1) |=> sdo_o == $past(word_o[WORD_W-2]));

  p_mode_frame_r6: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni)) |-> $stable(mode_q));

  p_sdo_hold_r7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> $stable(sdo_o));
endmodule

bind dcs_shift_out dcs_shift_out_chk #(.WORD_W(WORD_W)) u_chk (
  .sclk_i(sclk_i),
  .rst_ni(rst_ni),
  .cs_ni (cs_ni),
  .sdi_i (sdi_i),
  .mode_q(mode_q),
  .sdo_o (sdo_o),
  .word_o(word_o)
);

// File: tb/dcs_shift_out_tb.sv
module dcs_shift_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NVEC = 6;
  // {mode, word}
  localparam logic [W:0] VEC [NVEC] = '{
    {1'b0, 16'hA5C3}, {1'b1, 16'h3C96}, {1'b0, 16'hFFFF},
    {1'b1, 16'h0000}, {1'b1, 16'h8001}, {1'b0, 16'h5A5A}
  };

  logic sclk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sdi = 1'b0, mode = 1'b0;
  logic sdo, sdo2;
  logic [W-1:0] word, word2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  dcs_shift_out #(.WORD_W(W)) u_dut (
    .sclk_i(sclk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdi_i(sdi),
    .mode_i(mode), .sdo_o(sdo), .word_o(word));

  dcs_shift_out #(.WORD_W(W)) u_chain (
    .sclk_i(sclk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdi_i(sdo),
    .mode_i(mode), .sdo_o(sdo2), .word_o(word2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic msb_after(input logic [W-1:0] p, input logic [W-1:0] n, input int k);
    return (k < W) ? p[W-1-k] : n[2*W-1-k];
  endfunction

  logic [W-1:0] prev = '0;

  task automatic run_vec(input logic m, input logic [W-1:0] n);
    logic [W-1:0] hold;
    @(negedge sclk); #1;
    mode = m;
    @(negedge sclk); #1;
    cs_ni = 1'b0; sdi = n[W-1];
    for (int k = 1; k <= W; k++) begin
      @(posedge sclk); #2;
      // R5 rising mode shows new bit after rising edge; R4 falling mode not yet
      if (m) chk("R5", sdo, msb_after(prev, n, k));
      else   chk("R4", sdo, msb_after(prev, n, k-1));
      @(negedge sclk); #1;
      chk(m ? "R5" : "R4", sdo, msb_after(prev, n, k));
      if (k == 8) mode = ~m; // R6: must not alter this frame
      if (k < W) sdi = n[W-1-k];
      else cs_ni = 1'b1;
    end
    chk("R2", word, n);
    hold = word;
    for (int i = 0; i < 3; i++) begin
      sdi = ~sdi;
      @(negedge sclk); #1;
      chk("R3", word, hold);
      chk("R7", sdo, n[W-1]);
    end
    prev = n;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    repeat (2) @(negedge sclk);
    #1;
    chk("R1", word, 16'h0);
    chk("R1", sdo, 1'b0);
    rst_ni = 1'b1;
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v][W], VEC[v][W-1:0]);

    // R8: two-device chain, falling mode, 32 bits in one frame
    begin
      logic [2*W-1:0] stream;
      stream = 32'hC0DE_1234;
      @(negedge sclk); #1;
      mode = 1'b0;
      @(negedge sclk); #1;
      cs_ni = 1'b0; sdi = stream[2*W-1];
      for (int k = 1; k <= 2*W; k++) begin
        @(negedge sclk); #1;
        if (k < 2*W) sdi = stream[2*W-1-k];
        else cs_ni = 1'b1;
      end
      chk("R8", word, stream[W-1:0]);
      chk("R8", word2, stream[2*W-1:W]);
    end

    // R1: reset mid-state clears everything again
    @(negedge sclk); #1;
    rst_ni = 1'b0;
    #1;
    chk("R1", word, 16'h0);
    chk("R1", sdo, 1'b0);
    chk("R1", word2, 16'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule